// File: doc/BRIEF.md
# Seven-Level Multicarrier Sinusoidal PWM Modulator

This block produces the switching commands for a three-phase inverter with seven output levels and clamping diodes. For each phase it compares one sinusoidal reference against six triangular carriers, each carrier offset in level from the others. Every comparison gives one command bit. The number of bits that are set is the level the phase leg should apply, from 0 to 6, with 3 as the neutral point.

A shared timebase drives everything. A carrier counter runs with a period of `2*HALF` clocks. A reference phase counter runs with a period of `2*HALF*FREQ_RATIO` clocks, which is 640 at the defaults. The three phase references come from one computed sine table at 0, 120 and 240 degrees. Each is scaled by a modulation-index word.

The strategy input selects one of five carrier arrangements at run time:

- stacked in-phase bands;
- the lower half inverted;
- alternate bands inverted;
- half-overlapping bands;
- mixed carrier frequency.

A new selection is taken only at a carrier period boundary.

Top module: `ml_spwm_modulator`

## Requirements
- R1: A rising edge with `rst` high clears all comparator bits and levels, returns both counters to 0 and selects strategy 0. The outputs after the k-th edge following reset use carrier count `k mod 2*HALF` and phase count `k mod 2*HALF*FREQ_RATIO`.
- R2: Outputs are registered one edge after their inputs. Comparator bit j (bit 0 is the lowest carrier) is 1 exactly when the phase reference is strictly greater than carrier j.
- R3: Strategy code 0 (stacked bands): carrier j = (j-3)*HALF + r. Here r = c for c < HALF and 2*HALF-c otherwise, where c is the carrier count.
- R4: Strategy code 1: carriers 3 to 5 are as in R3. Carriers 0 to 2 use HALF-r in place of r.
- R5: Strategy code 2: even-numbered carriers are as in R3. Odd-numbered carriers use HALF-r.
- R6: Strategy code 3 (overlapping bands): carrier j = j*HALF/2 - (HALF + 5*HALF/2)/2 + r. Adjacent carriers therefore differ by HALF/2, and the set is centred on zero.
- R7: Strategy code 4 (mixed frequency): carriers 0 and 5 are as in R3. Carriers 1 to 4 use a ramp at twice the rate, r2 = 2*d for d < HALF/2 and 2*(HALF-d) otherwise, where d = c mod HALF.
- R8: The reference for phase p (0, 1, 2) is floor(S(i)*M*G / 2^21). The terms are:
  - the index is i = (n - p*P/3) mod P, with P = 640 and P/3 rounded down, where n is the phase count;
  - S(i) = sign * floor(4096*16*v / (5*h*h - 4*v)), with h = P/2, u = i mod h, v = u*(h-u), and the sign negative for i >= h;
  - M is the 10-bit modulation index in units of 1/512, so 512 means 1.0 and 410 means about 0.8;
  - G = 2*HALF in strategy 3 and 3*HALF otherwise.
- R9: Each phase level equals the number of set bits in its comparator word. The level is 3 bits wide and ranges 0 to 6.
- R10: `strat_sel` is sampled only on the edge where the carrier count equals 2*HALF-1. The new strategy applies from the next count of 0. Codes 5 to 7 act as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strat_sel | input | 3 | Requested carrier strategy code |
| mod_index | input | 10 | Modulation index, unsigned, 512 = 1.0 |
| cmp_a | output | 6 | Comparator bits, phase A |
| cmp_b | output | 6 | Comparator bits, phase B |
| cmp_c | output | 6 | Comparator bits, phase C |
| lvl_a | output | 3 | Output level, phase A |
| lvl_b | output | 3 | Output level, phase B |
| lvl_c | output | 3 | Output level, phase C |

## Verification
The bench changes the strategy code in the middle of carrier periods, and once changes it and changes it back within a single period. A design that switched at once would show wrong carrier shapes for the rest of that period. A zero modulation index puts the reference exactly on the carrier peaks and troughs, so any design that compares with greater-or-equal gives wrong bits and levels at those counts. The bench also drives the unused codes 5 to 7, a reduced index with the overlapping strategy's smaller gain, and the double-rate inner carriers. It applies a reset in the middle of the run, which catches designs that lose the counter alignment or the phase offsets.

// File: rtl/mcp_pkg.sv
package mcp_pkg;

    localparam int NUM_CAR = 6;
    localparam int NUM_PH  = 3;
    localparam int LVL_W   = $clog2(NUM_CAR + 1);

    typedef enum logic [2:0] {
        STR_PD   = 3'd0,
        STR_POD  = 3'd1,
        STR_APOD = 3'd2,
        STR_CO   = 3'd3,
        STR_VF   = 3'd4
    } strat_e;

    typedef struct packed {
        logic inv;   // ramp runs in the opposite direction
        logic dbl;   // ramp runs at twice the carrier rate
    } car_cfg_t;

    function automatic strat_e decode_strat(input logic [2:0] code);
        case (code)
            3'd1:    return STR_POD;
            3'd2:    return STR_APOD;
            3'd3:    return STR_CO;
            3'd4:    return STR_VF;
            default: return STR_PD;
        endcase
    endfunction

    function automatic car_cfg_t car_cfg(input strat_e m, input int j);
        car_cfg_t c;
        c.inv = 1'b0;
        c.dbl = 1'b0;
        case (m)
            STR_POD:  c.inv = (j < NUM_CAR / 2);
            STR_APOD: c.inv = (j % 2 == 1);
            STR_VF:   c.dbl = (j != 0) && (j != NUM_CAR - 1);
            default:  c.inv = 1'b0;
        endcase
        return c;
    endfunction

    // Lower edge of carrier j's band for a given strategy
    function automatic int car_floor(input strat_e m, input int j, input int half);
        if (m == STR_CO)
            return j * (half / 2) - (half + (NUM_CAR - 1) * (half / 2)) / 2;
        return (j - NUM_CAR / 2) * half;
    endfunction

    // Rational sine approximation, amplitude 2**frac, over pts samples
    function automatic int sine_sample(input int idx, input int pts, input int frac);
        longint half, u, v, num, den, s;
        half = longint'(pts / 2);
        u    = (longint'(idx) >= half) ? longint'(idx) - half : longint'(idx);
        v    = u * (half - u);
        num  = (longint'(1) << frac) * 16 * v;
        den  = 5 * half * half - 4 * v;
        s    = num / den;
        return (longint'(idx) >= half) ? -int'(s) : int'(s);
    endfunction

endpackage

// File: rtl/mcp_timebase.sv
module mcp_timebase
    import mcp_pkg::*;
#(
    parameter int HALF  = 16,
    parameter int PTS   = 640,
    parameter int CNT_W = 5,
    parameter int PH_W  = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       sel,
    output logic [CNT_W-1:0] cnt,
    output logic [PH_W-1:0]  ph,
    output strat_e           mode
);
    localparam int LAST = 2 * HALF - 1;

    logic at_end;
    assign at_end = (cnt == CNT_W'(LAST));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            ph   <= '0;
            mode <= STR_PD;
        end else begin
            cnt <= at_end ? '0 : cnt + 1'b1;
            ph  <= (ph == PH_W'(PTS - 1)) ? '0 : ph + 1'b1;
            if (at_end)
                mode <= decode_strat(sel);
        end
    end

    // R10: strategy only changes across a carrier period boundary
    p_mode_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !at_end |=> $stable(mode))
        else $error("strategy changed mid carrier period");

endmodule

// File: rtl/mcp_carriers.sv
module mcp_carriers
    import mcp_pkg::*;
#(
    parameter int HALF  = 16,
    parameter int CNT_W = 5,
    parameter int VW    = 9
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CNT_W-1:0]      cnt,
    input  strat_e                mode,
    output logic signed [VW-1:0]  car [NUM_CAR]
);
    int c_i, ramp_b, ramp_d, c_mod;

    always_comb begin
        c_i    = int'(cnt);
        ramp_b = (c_i < HALF) ? c_i : 2 * HALF - c_i;
        c_mod  = (c_i >= HALF) ? c_i - HALF : c_i;
        ramp_d = (c_mod < HALF / 2) ? 2 * c_mod : 2 * (HALF - c_mod);
    end

    for (genvar j = 0; j < NUM_CAR; j++) begin : g_car
        car_cfg_t cfg;
        int       t;
        always_comb begin
            cfg = car_cfg(mode, j);
            t   = cfg.dbl ? ramp_d : ramp_b;
            if (cfg.inv)
                t = HALF - t;
            car[j] = VW'(car_floor(mode, j, HALF) + t);
        end
    end

    for (genvar j = 0; j < NUM_CAR - 1; j++) begin : g_chk
        // R3: disposition bands never cross each other
        p_stack_r3: assert property (@(posedge clk) disable iff (rst)
            (mode != STR_CO) |-> (car[j+1] >= car[j]))
            else $error("carrier bands crossed");
        // R6: overlapping carriers sit half an amplitude apart
        p_co_offset_r6: assert property (@(posedge clk) disable iff (rst)
            (mode == STR_CO) |-> (int'(car[j+1]) - int'(car[j]) == HALF / 2))
            else $error("overlap offset wrong");
    end

endmodule

// File: rtl/mcp_reference.sv
module mcp_reference
    import mcp_pkg::*;
#(
    parameter int HALF       = 16,
    parameter int FREQ_RATIO = 20,
    parameter int MI_W       = 10,
    parameter int MI_FRAC    = 9,
    parameter int SIN_FRAC   = 12,
    parameter int PH_W       = 10,
    parameter int VW         = 9
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PH_W-1:0]       ph,
    input  strat_e                mode,
    input  logic [MI_W-1:0]       mi,
    output logic signed [VW-1:0]  ref_v [NUM_PH]
);
    localparam int PTS   = 2 * HALF * FREQ_RATIO;
    localparam int SW    = SIN_FRAC + 2;
    localparam int SHIFT = SIN_FRAC + MI_FRAC;

    logic signed [SW-1:0] rom [PTS];

    for (genvar i = 0; i < PTS; i++) begin : g_rom
        assign rom[i] = SW'(sine_sample(i, PTS, SIN_FRAC));
    end

    int gain;
    assign gain = (mode == STR_CO) ? 2 * HALF : (NUM_CAR / 2) * HALF;

    for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
        localparam int OFF = (p * PTS) / NUM_PH;
        int idx, prod, lim;
        always_comb begin
            idx = int'(ph) + PTS - OFF;
            if (idx >= PTS)
                idx = idx - PTS;
            prod     = int'(rom[PH_W'(idx)]) * int'(mi) * gain;
            ref_v[p] = VW'(prod >>> SHIFT);
            lim      = (gain * int'(mi)) >>> MI_FRAC;
        end

        // R8: scaled reference never exceeds the index-scaled amplitude
        p_ref_bound_r8: assert property (@(posedge clk) disable iff (rst)
            (int'(ref_v[p]) <= lim) && (int'(ref_v[p]) >= -lim - 1))
            else $error("reference out of scaled range");
    end

endmodule

// File: rtl/mcp_compare.sv
module mcp_compare
    import mcp_pkg::*;
#(
    parameter int VW = 9
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic signed [VW-1:0]  ref_v,
    input  logic signed [VW-1:0]  car [NUM_CAR],
    output logic [NUM_CAR-1:0]    cmp_q,
    output logic [LVL_W-1:0]      lvl_q
);
    logic [NUM_CAR-1:0] hit;
    logic [LVL_W-1:0]   ones;

    for (genvar j = 0; j < NUM_CAR; j++) begin : g_cmp
        assign hit[j] = (ref_v > car[j]);
    end

    always_comb begin
        ones = '0;
        for (int j = 0; j < NUM_CAR; j++)
            ones = ones + LVL_W'(hit[j]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
            lvl_q <= '0;
        end else begin
            cmp_q <= hit;
            lvl_q <= ones;
        end
    end

    // R1: the edge taken in reset leaves every command cleared
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cmp_q == '0) && (lvl_q == '0))
        else $error("outputs not cleared by reset");

endmodule

// File: rtl/ml_spwm_modulator.sv
module ml_spwm_modulator
    import mcp_pkg::*;
#(
    parameter int HALF       = 16,
    parameter int FREQ_RATIO = 20,
    parameter int MI_W       = 10,
    parameter int MI_FRAC    = 9,
    parameter int SIN_FRAC   = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         strat_sel,
    input  logic [MI_W-1:0]    mod_index,
    output logic [NUM_CAR-1:0] cmp_a,
    output logic [NUM_CAR-1:0] cmp_b,
    output logic [NUM_CAR-1:0] cmp_c,
    output logic [LVL_W-1:0]   lvl_a,
    output logic [LVL_W-1:0]   lvl_b,
    output logic [LVL_W-1:0]   lvl_c
);
    localparam int PTS   = 2 * HALF * FREQ_RATIO;
    localparam int CNT_W = $clog2(2 * HALF);
    localparam int PH_W  = $clog2(PTS);
    localparam int VW    = $clog2((NUM_CAR / 2) * HALF * (2 ** (MI_W - MI_FRAC)) + 1) + 2;

    logic [CNT_W-1:0]     cnt;
    logic [PH_W-1:0]      ph;
    strat_e               mode;
    logic signed [VW-1:0] car   [NUM_CAR];
    logic signed [VW-1:0] ref_v [NUM_PH];
    logic [NUM_CAR-1:0]   cmp_w [NUM_PH];
    logic [LVL_W-1:0]     lvl_w [NUM_PH];

    mcp_timebase #(.HALF(HALF), .PTS(PTS), .CNT_W(CNT_W), .PH_W(PH_W)) u_tb (
        .clk(clk), .rst(rst), .sel(strat_sel), .cnt(cnt), .ph(ph), .mode(mode)
    );

    mcp_carriers #(.HALF(HALF), .CNT_W(CNT_W), .VW(VW)) u_car (
        .clk(clk), .rst(rst), .cnt(cnt), .mode(mode), .car(car)
    );

    mcp_reference #(
        .HALF(HALF), .FREQ_RATIO(FREQ_RATIO), .MI_W(MI_W), .MI_FRAC(MI_FRAC),
        .SIN_FRAC(SIN_FRAC), .PH_W(PH_W), .VW(VW)
    ) u_ref (
        .clk(clk), .rst(rst), .ph(ph), .mode(mode), .mi(mod_index), .ref_v(ref_v)
    );

    for (genvar p = 0; p < NUM_PH; p++) begin : g_leg
        mcp_compare #(.VW(VW)) u_cmp (
            .clk(clk), .rst(rst), .ref_v(ref_v[p]), .car(car),
            .cmp_q(cmp_w[p]), .lvl_q(lvl_w[p])
        );

        for (genvar j = 0; j < NUM_CAR - 1; j++) begin : g_th
            // R3: in non-overlapping arrangements the bits form a thermometer code
            p_thermo_r3: assert property (@(posedge clk) disable iff (rst)
                (($past(mode) != STR_CO) && cmp_w[p][j+1]) |-> cmp_w[p][j])
                else $error("comparator word not a thermometer code");
        end
    end

    assign cmp_a = cmp_w[0];
    assign cmp_b = cmp_w[1];
    assign cmp_c = cmp_w[2];
    assign lvl_a = lvl_w[0];
    assign lvl_b = lvl_w[1];
    assign lvl_c = lvl_w[2];

endmodule

// File: tb/tb_ml_spwm_modulator.sv
module tb_ml_spwm_modulator;
    localparam int CLK_P   = 10;
    localparam int H       = 16;
    localparam int PTS     = 640;
    localparam int SHIFT_T = 21;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] sel = 3'd0;
    logic [9:0] mi  = 10'd512;
    logic [5:0] cmp_a, cmp_b, cmp_c;
    logic [2:0] lvl_a, lvl_b, lvl_c;

    ml_spwm_modulator dut (
        .clk(clk), .rst(rst), .strat_sel(sel), .mod_index(mi),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c),
        .lvl_a(lvl_a), .lvl_b(lvl_b), .lvl_c(lvl_c)
    );

    always #(CLK_P / 2) clk = ~clk;

    typedef struct packed {
        logic [2:0][5:0] c;
        logic [2:0][2:0] l;
        logic [3:0]      md;   // 15 marks a reset cycle
    } item_t;

    item_t sbq[$];
    int    errors = 0;
    int    checks = 0;
    int    m_cnt  = 0;
    int    m_ph   = 0;
    int    m_mode = 0;
    bit    done   = 0;

    function automatic int ramp1(input int c);
        return (c < H) ? c : 2 * H - c;
    endfunction

    function automatic int ramp2(input int c);
        int d;
        d = c % H;
        return (d < H / 2) ? 2 * d : 2 * (H - d);
    endfunction

    function automatic int carrier(input int md, input int j, input int c);
        int base;
        base = (j - 3) * H;
        case (md)
            1:       return base + ((j < 3) ? H - ramp1(c) : ramp1(c));
            2:       return base + ((j % 2 == 1) ? H - ramp1(c) : ramp1(c));
            3:       return j * (H / 2) - (H + 5 * (H / 2)) / 2 + ramp1(c);
            4:       return base + ((j == 0 || j == 5) ? ramp1(c) : ramp2(c));
            default: return base + ramp1(c);
        endcase
    endfunction

    function automatic int sine_t(input int i);
        longint h, u, v, s;
        h = PTS / 2;
        u = (i >= h) ? i - h : i;
        v = u * (h - u);
        s = (longint'(4096) * 16 * v) / (5 * h * h - 4 * v);
        return (i >= h) ? -int'(s) : int'(s);
    endfunction

    function automatic int refv(input int md, input int n, input int p, input int m);
        int i, g;
        i = (n - (p * PTS) / 3 + PTS) % PTS;
        g = (md == 3) ? 2 * H : 3 * H;
        return (sine_t(i) * m * g) >>> SHIFT_T;
    endfunction

    function automatic int decode_t(input logic [2:0] s);
        return (s <= 3'd4) ? int'(s) : 0;
    endfunction

    function automatic string mode_tag(input logic [3:0] md);
        case (md)
            4'd0:    return "R3 stacked";
            4'd1:    return "R4 lower-inverted";
            4'd2:    return "R5 alternate";
            4'd3:    return "R6 overlap";
            4'd4:    return "R7 mixed-rate";
            default: return "R1 reset";
        endcase
    endfunction

    // Driver side: model advances with each edge and queues what the next outputs must be
    always @(posedge clk) begin
        item_t it;
        int    r;
        it = '0;
        if (rst) begin
            it.md  = 4'hF;
            m_cnt  = 0;
            m_ph   = 0;
            m_mode = 0;
        end else begin
            it.md = 4'(m_mode);
            for (int p = 0; p < 3; p++) begin
                r = refv(m_mode, m_ph, p, int'(mi));
                for (int j = 0; j < 6; j++) begin
                    if (r > carrier(m_mode, j, m_cnt)) begin
                        it.c[p][j] = 1'b1;
                        it.l[p]    = it.l[p] + 3'd1;
                    end
                end
            end
            if (m_cnt == 2 * H - 1)
                m_mode = decode_t(sel);
            m_cnt = (m_cnt + 1) % (2 * H);
            m_ph  = (m_ph + 1) % PTS;
        end
        sbq.push_back(it);
    end

    // Monitor side: compare design outputs against the queued expectations
    always @(negedge clk) begin
        item_t      e;
        logic [5:0] gc;
        logic [2:0] gl;
        if (sbq.size() > 0 && !done) begin
            e = sbq.pop_front();
            for (int p = 0; p < 3; p++) begin
                gc = (p == 0) ? cmp_a : (p == 1) ? cmp_b : cmp_c;
                gl = (p == 0) ? lvl_a : (p == 1) ? lvl_b : lvl_c;
                checks++;
                if (gc !== e.c[p]) begin
                    errors++;
                    $display("FAIL R2 R8 R10 %s phase %0d cmp: actual=%b expected=%b",
                             mode_tag(e.md), p, gc, e.c[p]);
                end
                checks++;
                if (gl !== e.l[p]) begin
                    errors++;
                    $display("FAIL R9 %s phase %0d level: actual=%0d expected=%0d",
                             mode_tag(e.md), p, gl, e.l[p]);
                end
            end
        end
    end

    task automatic seg(input logic [2:0] s, input logic [9:0] m, input int n);
        @(negedge clk);
        sel = s;
        mi  = m;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        seg(3'd0, 10'd512, 700);   // R3
        seg(3'd1, 10'd512, 700);   // R4
        seg(3'd2, 10'd512, 700);   // R5
        seg(3'd3, 10'd512, 700);   // R6
        seg(3'd4, 10'd512, 700);   // R7
        seg(3'd6, 10'd512, 100);   // R10 unused code
        seg(3'd1, 10'd410, 400);   // R8 reduced index
        seg(3'd3, 10'd410, 400);
        seg(3'd4, 10'd461, 400);
        seg(3'd2, 10'd410, 7);     // R10 request withdrawn inside one period
        seg(3'd0, 10'd410, 300);
        seg(3'd0, 10'd0, 100);     // R2 ties at carrier extremes
        seg(3'd3, 10'd0, 100);
        seg(3'd5, 10'd410, 200);
        rst = 1'b1;                // R1 reset in mid run
        repeat (3) @(negedge clk);
        rst = 1'b0;
        seg(3'd2, 10'd512, 400);
        seg(3'd7, 10'd1000, 200);
        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL R1 watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule